// File: doc/BRIEF.md
# Multi-Word Synchronous Command Loader

This block sits at the front of a pipelined command port. Each cycle in which the active-low input enable is low, it takes a 4-bit opcode and one data word. The data bus is 32 bits wide, or 16 bits when the narrow-mode pin is high. Operands that are wider than the bus arrive over several cycles, least significant word first. Each word sits right-aligned on the bus. The opcode tags every word: the LOAD code marks a partial word, and any other code marks the last word, names the operation and hands the assembled operand to the execution stage.

The return path mirrors the input path. The block takes a result word from the execution stage when it is idle. It then presents the result on the output bus one word at a time, least significant word first. An active-low valid strobe qualifies each word, and an active-low output enable lets the consumer hold the unloading. The input and output halves run independently, so the next command can be assembled and dispatched while the previous result is still being shifted out.

Top module: `cmdld_port`

## Requirements
- R1: While reset is held and just after it, cmd_valid and load_err are 0, dout_val_n is 1 and res_ready is 1.
- R2: A cycle with din_en_n high has no effect: its op and din are ignored and do not enter the operand.
- R3: With narrow = 0, a command of LOAD w0 followed by op X with w1 yields cmd_op = X and cmd_opnd = {w1, w0}. cmd_valid is high for exactly the one cycle after the edge that sampled the final word.
- R4: With narrow = 1, only din[15:0] is used. Four words w0..w3 form cmd_opnd = {w3, w2, w1, w0} in 16-bit fields, and din[31:16] is ignored.
- R5: A non-LOAD word with no preceding LOAD words dispatches a single-word operand. Every bit above that word is zero, even when it follows a longer command.
- R6: The LOAD opcode is 4'h0 and never dispatches. Every other code (4'h1 to 4'hF) dispatches.
- R7: LOAD words beyond the operand capacity (OPND_W/32 words wide, OPND_W/16 narrow) are dropped. The operand keeps the first words, and load_err goes to 1 and stays 1 until reset. A final word that arrives at full capacity is also dropped and also sets load_err.
- R8: With narrow = 0, a RES_W-bit result accepted on res_valid & res_ready is output as RES_W/32 words on dout[31:0], least significant word first. dout_val_n is low for each word, starting in the cycle after acceptance.
- R9: With narrow = 1, the result goes out as RES_W/16 words on dout[15:0], least significant first, with dout[31:16] = 0.
- R10: While oe_n is high, dout_val_n is 1 and the current word is held. Unloading resumes with that same word, and no word is lost.
- R11: res_ready is 0 from acceptance until the last word has gone out. Commands can be loaded and dispatched while unloading is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| narrow | input | 1 | 1 selects 16-bit bus words, 0 selects 32-bit |
| din_en_n | input | 1 | Active-low input enable |
| op | input | 4 | Opcode; 4'h0 = LOAD |
| din | input | 32 | Command data word, right aligned |
| cmd_valid | output | 1 | One-cycle dispatch strobe |
| cmd_op | output | 4 | Dispatched operation |
| cmd_opnd | output | OPND_W | Assembled operand |
| load_err | output | 1 | Sticky overflow flag |
| res_valid | input | 1 | Result offered by the execution stage |
| res_data | input | RES_W | Result value |
| res_ready | output | 1 | Serializer idle, result can be accepted |
| oe_n | input | 1 | Active-low output enable (stall when high) |
| dout | output | 32 | Result word |
| dout_val_n | output | 1 | Active-low result-word valid |

## Verification
Commands are sent in both bus widths. Using distinct word values shows whether words land in the correct fields and in least-significant-first order. Idle cycles with junk placed between words check that the enable gates sampling. Single-word commands sent right after a long one expose stale upper bits. Overflow sequences show that capacity follows the selected mode and that the error flag is sticky. Results are unloaded with and without stalls, and also at the same time as a command load, which separates the two halves of the port.

// File: rtl/cmdld_pkg.sv
package cmdld_pkg;
  typedef logic [3:0] opcode_t;
  localparam opcode_t OP_LOAD  = 4'h0;
  localparam int      WIDE_W   = 32;
  localparam int      NARROW_W = 16;

  // number of bus words a field of 'bits' bits occupies in the chosen mode
  function automatic int words_for(input int bits, input logic nar);
    return nar ? bits / NARROW_W : bits / WIDE_W;
  endfunction
endpackage

// File: rtl/cmdld_assembler.sv
module cmdld_assembler
  import cmdld_pkg::*;
#(
  parameter int OPND_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              narrow,
  input  logic              din_en_n,
  input  opcode_t           op,
  input  logic [31:0]       din,
  output logic              cmd_valid,
  output opcode_t           cmd_op,
  output logic [OPND_W-1:0] cmd_opnd,
  output logic              load_err
);
  localparam int MAX_WORDS = OPND_W / NARROW_W;
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);

  logic [OPND_W-1:0] acc;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [OPND_W-1:0] place(input logic [OPND_W-1:0] a,
                                               input logic [31:0] w,
                                               input logic [CNT_W-1:0] idx,
                                               input logic nar);
    logic [OPND_W-1:0] msk, val;
    int sh;
    sh  = nar ? int'(idx) * NARROW_W : int'(idx) * WIDE_W;
    msk = nar ? OPND_W'({NARROW_W{1'b1}}) : OPND_W'({WIDE_W{1'b1}});
    val = nar ? OPND_W'(w[NARROW_W-1:0]) : OPND_W'(w);
    msk = msk << sh;
    val = val << sh;
    return (a & ~msk) | (val & msk);
  endfunction

  // named events for checking
  logic              take, is_load, room, ovf_evt, dispatch_evt;
  logic [CNT_W-1:0]  limit;
  logic [OPND_W-1:0] merged;

  assign take         = !din_en_n;
  assign is_load      = (op == OP_LOAD);
  assign limit        = CNT_W'(words_for(OPND_W, narrow));
  assign room         = (cnt < limit);
  assign ovf_evt      = take && !room;
  assign dispatch_evt = take && !is_load;
  assign merged       = place(acc, din, cnt, narrow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      cnt       <= '0;
      cmd_valid <= 1'b0;
      cmd_op    <= OP_LOAD;
      cmd_opnd  <= '0;
      load_err  <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      if (ovf_evt) load_err <= 1'b1;
      if (take) begin
        if (is_load) begin
          if (room) begin
            acc <= merged;
            cnt <= cnt + 1'b1;
          end
        end else begin
          cmd_valid <= 1'b1;
          cmd_op    <= op;
          cmd_opnd  <= room ? merged : acc;
          acc       <= '0;
          cnt       <= '0;
        end
      end
    end
  end

  // R3: a dispatch strobe is always caused by an enabled word one cycle earlier
  a_r3_dispatch_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(!din_en_n));
  // R6: a LOAD word never produces a dispatch
  a_r6_load_no_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_load) |=> !cmd_valid);
  // R7: the error flag is sticky
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |=> load_err);
  // R7: word count never passes capacity
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_WORDS));
  // R5: single-word command carries nothing above its one word
  a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch_evt && cnt == '0) |=>
      ((cmd_opnd >> ($past(narrow) ? NARROW_W : WIDE_W)) == '0));
endmodule

// File: rtl/cmdld_serializer.sv
module cmdld_serializer
  import cmdld_pkg::*;
#(
  parameter int RES_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             narrow,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  output logic             res_ready,
  input  logic             oe_n,
  output logic [31:0]      dout,
  output logic             dout_val_n
);
  localparam int MAX_WORDS = RES_W / NARROW_W;
  localparam int LEFT_W    = $clog2(MAX_WORDS + 1);

  logic [RES_W-1:0]  shreg;
  logic [LEFT_W-1:0] left;
  logic              nar_q;

  logic busy, accept_evt, advance_evt;
  assign busy        = (left != '0);
  assign accept_evt  = res_valid && res_ready;
  assign advance_evt = busy && !oe_n;

  assign res_ready  = !busy;
  assign dout       = nar_q ? {16'h0000, shreg[NARROW_W-1:0]} : shreg[WIDE_W-1:0];
  assign dout_val_n = !advance_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
      nar_q <= 1'b0;
    end else if (accept_evt) begin
      shreg <= res_data;
      left  <= LEFT_W'(words_for(RES_W, narrow));
      nar_q <= narrow;
    end else if (advance_evt) begin
      shreg <= nar_q ? (shreg >> NARROW_W) : (shreg >> WIDE_W);
      left  <= left - 1'b1;
    end
  end

  // R10: a stalled word is held unchanged
  a_r10_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && oe_n) |=> $stable(shreg));
  // R10: no valid strobe while output enable is off
  a_r10_no_val_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> dout_val_n);
  // R11: acceptance closes the ready window
  a_r11_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !res_ready);
  // R8: remaining count bounded by the word count of the result
  a_r8_left_bound: assert property (@(posedge clk) disable iff (!rst_n)
    left <= LEFT_W'(MAX_WORDS));
endmodule

// File: rtl/cmdld_port.sv
module cmdld_port
  import cmdld_pkg::*;
#(
  parameter int OPND_W = 64,
  parameter int RES_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              narrow,
  input  logic              din_en_n,
  input  logic [3:0]        op,
  input  logic [31:0]       din,
  output logic              cmd_valid,
  output logic [3:0]        cmd_op,
  output logic [OPND_W-1:0] cmd_opnd,
  output logic              load_err,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  output logic              res_ready,
  input  logic              oe_n,
  output logic [31:0]       dout,
  output logic              dout_val_n
);
  cmdld_assembler #(.OPND_W(OPND_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .narrow(narrow), .din_en_n(din_en_n),
    .op(op), .din(din), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_opnd(cmd_opnd), .load_err(load_err)
  );

  cmdld_serializer #(.RES_W(RES_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .narrow(narrow), .res_valid(res_valid),
    .res_data(res_data), .res_ready(res_ready), .oe_n(oe_n),
    .dout(dout), .dout_val_n(dout_val_n)
  );

  // R1: an idle port shows no result strobe
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |-> dout_val_n);
endmodule

// File: tb/cmdld_port_bench.sv
module cmdld_port_bench;
  localparam int OPND_W = 64;
  localparam int RES_W  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic narrow = 1'b0;
  logic din_en_n = 1'b1;
  logic [3:0] op = 4'h0;
  logic [31:0] din = '0;
  logic cmd_valid, load_err, res_ready, dout_val_n;
  logic [3:0] cmd_op;
  logic [OPND_W-1:0] cmd_opnd;
  logic res_valid = 1'b0;
  logic [RES_W-1:0] res_data = '0;
  logic oe_n = 1'b0;
  logic [31:0] dout;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  cmdld_port #(.OPND_W(OPND_W), .RES_W(RES_W)) u_cmdld_port (
    .clk(clk), .rst_n(rst_n), .narrow(narrow), .din_en_n(din_en_n),
    .op(op), .din(din), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_opnd(cmd_opnd), .load_err(load_err), .res_valid(res_valid),
    .res_data(res_data), .res_ready(res_ready), .oe_n(oe_n),
    .dout(dout), .dout_val_n(dout_val_n)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one enabled word at a negedge, return at the next negedge
  task automatic send(input logic [3:0] o, input logic [31:0] d);
    din_en_n = 1'b0; op = o; din = d;
    @(negedge clk);
    din_en_n = 1'b1; op = 4'h7; din = 32'hDEAD_BEEF;
  endtask

  task automatic check_cmd(input string req, input logic [3:0] eo,
                           input logic [63:0] ed);
    chk(cmd_valid === 1'b1, req, 64'(cmd_valid), 64'd1);
    chk(cmd_op === eo, req, 64'(cmd_op), 64'(eo));
    chk(cmd_opnd === ed, req, cmd_opnd, ed);
    @(negedge clk);
    chk(cmd_valid === 1'b0, req, 64'(cmd_valid), 64'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmd_valid === 1'b0 && load_err === 1'b0, "R1 in reset",
        {62'd0, cmd_valid, load_err}, 64'd0);
    chk(dout_val_n === 1'b1 && res_ready === 1'b1, "R1 in reset out",
        {62'd0, dout_val_n, res_ready}, 64'd3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_valid === 1'b0 && load_err === 1'b0 && dout_val_n === 1'b1,
        "R1 after reset", {61'd0, cmd_valid, load_err, dout_val_n}, 64'd1);
  endtask

  task automatic t_wide_and_gate();
    narrow = 1'b0;
    send(4'h0, 32'h1111_2222);
    // R2: disabled cycles with junk on the bus
    din_en_n = 1'b1; op = 4'h9; din = 32'hBAD0_BAD0;
    repeat (2) @(negedge clk);
    chk(cmd_valid === 1'b0, "R2 disabled no dispatch", 64'(cmd_valid), 64'd0);
    send(4'h5, 32'h3333_4444);
    check_cmd("R3 wide two-word", 4'h5, 64'h3333_4444_1111_2222);
  endtask

  task automatic t_narrow();
    narrow = 1'b1;
    send(4'h0, 32'hFFFF_000A);
    send(4'h0, 32'hEEEE_000B);
    send(4'h0, 32'hDDDD_000C);
    send(4'hC, 32'hCCCC_000D);
    check_cmd("R4 narrow four-word", 4'hC, 64'h000D_000C_000B_000A);
    narrow = 1'b0;
  endtask

  task automatic t_single_and_codes();
    send(4'h1, 32'hABCD_1234);
    check_cmd("R5 single wide zero-fill", 4'h1, 64'h0000_0000_ABCD_1234);
    narrow = 1'b1;
    send(4'hF, 32'hABCD_1234);
    check_cmd("R5 single narrow zero-fill", 4'hF, 64'h0000_0000_0000_1234);
    narrow = 1'b0;
    send(4'h0, 32'h5555_5555);
    chk(cmd_valid === 1'b0, "R6 LOAD no dispatch", 64'(cmd_valid), 64'd0);
    send(4'hA, 32'h6666_6666);
    check_cmd("R6 nonzero code dispatches", 4'hA, 64'h6666_6666_5555_5555);
  endtask

  task automatic t_overflow();
    narrow = 1'b0;
    chk(load_err === 1'b0, "R7 clear before overflow", 64'(load_err), 64'd0);
    send(4'h0, 32'hA0A0_A0A0);
    send(4'h0, 32'hB1B1_B1B1);
    chk(load_err === 1'b0, "R7 clear at capacity", 64'(load_err), 64'd0);
    send(4'h0, 32'hC2C2_C2C2);
    chk(load_err === 1'b1, "R7 flag set", 64'(load_err), 64'd1);
    send(4'h3, 32'hD3D3_D3D3);
    check_cmd("R7 saturated operand", 4'h3, 64'hB1B1_B1B1_A0A0_A0A0);
    send(4'h2, 32'h0000_0042);
    check_cmd("R7 next command after overflow", 4'h2, 64'h42);
    chk(load_err === 1'b1, "R7 sticky", 64'(load_err), 64'd1);
    do_reset();
    chk(load_err === 1'b0, "R7 cleared by reset", 64'(load_err), 64'd0);
  endtask

  task automatic offer(input logic [RES_W-1:0] r);
    chk(res_ready === 1'b1, "R11 ready when idle", 64'(res_ready), 64'd1);
    res_valid = 1'b1; res_data = r;
    @(negedge clk);
    res_valid = 1'b0; res_data = '0;
  endtask

  task automatic t_unload_wide();
    narrow = 1'b0; oe_n = 1'b0;
    offer(64'h8765_4321_0FED_CBA9);
    chk(dout_val_n === 1'b0 && dout === 32'h0FED_CBA9, "R8 word0",
        {31'd0, dout_val_n, dout}, 64'h0FED_CBA9);
    chk(res_ready === 1'b0, "R11 busy not ready", 64'(res_ready), 64'd0);
    @(negedge clk);
    chk(dout_val_n === 1'b0 && dout === 32'h8765_4321, "R8 word1",
        {31'd0, dout_val_n, dout}, 64'h8765_4321);
    @(negedge clk);
    chk(dout_val_n === 1'b1 && res_ready === 1'b1, "R8 done",
        {62'd0, dout_val_n, res_ready}, 64'd3);
  endtask

  task automatic t_unload_narrow_stall();
    logic [63:0] r;
    r = 64'h4444_3333_2222_1111;
    narrow = 1'b1; oe_n = 1'b0;
    offer(r);
    for (int i = 0; i < 4; i++) begin
      if (i == 2) begin
        oe_n = 1'b1;
        #1;
        chk(dout_val_n === 1'b1, "R10 stalled no valid", 64'(dout_val_n), 64'd1);
        repeat (3) @(negedge clk);
        chk(dout === 32'h0000_3333, "R10 word held", 64'(dout), 64'h3333);
        oe_n = 1'b0;
        #1;
      end
      chk(dout_val_n === 1'b0 && dout === {16'h0, r[i*16 +: 16]}, "R9 narrow word",
          {31'd0, dout_val_n, dout}, {32'd0, 16'h0, r[i*16 +: 16]});
      @(negedge clk);
    end
    chk(dout_val_n === 1'b1 && res_ready === 1'b1, "R9 done",
        {62'd0, dout_val_n, res_ready}, 64'd3);
    narrow = 1'b0;
  endtask

  task automatic t_overlap();
    narrow = 1'b0; oe_n = 1'b0;
    offer(64'hCAFE_0002_CAFE_0001);
    chk(dout === 32'hCAFE_0001 && dout_val_n === 1'b0, "R11 overlap word0",
        {31'd0, dout_val_n, dout}, 64'hCAFE_0001);
    send(4'h0, 32'h0101_0101);
    chk(dout === 32'hCAFE_0002 && res_ready === 1'b0, "R11 overlap word1",
        {31'd0, res_ready, dout}, 64'hCAFE_0002);
    send(4'h6, 32'h0202_0202);
    chk(dout_val_n === 1'b1, "R11 unload finished", 64'(dout_val_n), 64'd1);
    check_cmd("R11 command during unload", 4'h6, 64'h0202_0202_0101_0101);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_wide_and_gate();
    t_narrow();
    t_single_and_codes();
    t_overflow();
    t_unload_wide();
    t_unload_narrow_stall();
    t_overlap();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule